// File: doc/BRIEF.md
# Integer ALU with Comparison Flags

A purely combinational integer arithmetic-logic unit for the execute stage of a small RISC-style processor. Two operands and a 4-bit function code go in. A data result and three comparison flags come out: equal, signed less-than and unsigned less-than.

The flags are produced on every cycle, whatever function is selected. Branch logic can therefore read them alongside any data result. One function forms a jump target by adding the operands and clearing bit 0 of the sum. A dedicated unsigned-compare function drives a zero data result, so only its flags carry information.

The unit holds no state and has no clock. Its width is set by a parameter, 32 by default.

Top module: `int_alu`

## Requirements
- R1: Function code 0 returns opa + opb, wrapping modulo 2^WIDTH (0xfeeeeaa3 + 0xf4650000 = 0xf353eaa3).
- R2: Function code 1 returns opa - opb in two's complement (0x00000001 - 0xffffffff = 0x00000002).
- R3: Function codes 2, 3 and 4 return bitwise AND, OR and XOR of the operands respectively.
- R4: Function code 10 returns opa + opb with bit 0 forced to 0 (0xfff0a440 + 0x00000fff = 0xfff0b43e).
- R5: Function code 14 returns an all-zero data result; its outcome appears only on the flags.
- R6: flag_eq is 1 exactly when opa equals opb.
- R7: flag_lt is 1 exactly when opa < opb as signed two's-complement values.
- R8: flag_ltu is 1 exactly when opa < opb as unsigned values.
- R9: Function codes 5, 6 and 7 shift opa left logically, right logically and right arithmetically. The shift amount is the low log2(WIDTH) bits of opb, and the higher bits of opb are ignored.
- R10: Function code 8 returns opb unchanged.
- R11: Function codes 9, 11, 12, 13 and 15 return an all-zero data result.
- R12: All three flags are valid for every function code, not only for code 14.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | WIDTH | First operand |
| opb | input | WIDTH | Second operand, also the shift amount source |
| func | input | 4 | Function select code |
| result | output | WIDTH | Data result |
| flag_eq | output | 1 | Operands equal |
| flag_lt | output | 1 | opa below opb, signed |
| flag_ltu | output | 1 | opa below opb, unsigned |

## Verification
The data path and the comparison flags are evaluated in the same cycle for every code, so a fault can appear in either one while the other looks correct. The bench provokes this with operand pairs that differ only in the sign bit. For such pairs the signed and unsigned flags must disagree, and this is checked under the compare code, where the data result must stay zero, and under arithmetic codes, where the data result is nonzero. Every vector is judged on all four outputs at once against a bench model.

// File: rtl/int_alu.sv
module int_alu #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] opa,
  input  logic [WIDTH-1:0] opb,
  input  logic [3:0]       func,
  output logic [WIDTH-1:0] result,
  output logic             flag_eq,
  output logic             flag_lt,
  output logic             flag_ltu
);

  localparam int SHW = $clog2(WIDTH);

  localparam logic [3:0] F_ADD  = 4'd0;
  localparam logic [3:0] F_SUB  = 4'd1;
  localparam logic [3:0] F_AND  = 4'd2;
  localparam logic [3:0] F_OR   = 4'd3;
  localparam logic [3:0] F_XOR  = 4'd4;
  localparam logic [3:0] F_SLL  = 4'd5;
  localparam logic [3:0] F_SRL  = 4'd6;
  localparam logic [3:0] F_SRA  = 4'd7;
  localparam logic [3:0] F_PASS = 4'd8;
  localparam logic [3:0] F_JTGT = 4'd10;
  localparam logic [3:0] F_CMPU = 4'd14;

  logic [WIDTH-1:0] sum;
  logic [WIDTH-1:0] diff;
  logic [SHW-1:0]   shamt;
  logic             eq_w, lt_w, ltu_w;
  logic [WIDTH-1:0] res_w;

  assign sum   = opa + opb;
  assign diff  = opa - opb;
  assign shamt = opb[SHW-1:0];

  always_comb begin
    eq_w  = (opa == opb);
    ltu_w = (opa < opb);
    lt_w  = ($signed(opa) < $signed(opb));

    unique case (func)
      F_ADD:   res_w = sum;
      F_SUB:   res_w = diff;
      F_AND:   res_w = opa & opb;
      F_OR:    res_w = opa | opb;
      F_XOR:   res_w = opa ^ opb;
      F_SLL:   res_w = opa << shamt;
      F_SRL:   res_w = opa >> shamt;
      F_SRA:   res_w = WIDTH'($signed(opa) >>> shamt);
      F_PASS:  res_w = opb;
      F_JTGT:  res_w = {sum[WIDTH-1:1], 1'b0};
      F_CMPU:  res_w = '0;
      default: res_w = '0;
    endcase

    AST_CMPU_ZERO: assert (func != F_CMPU || res_w == '0) else $error("compare code drove data"); // R5
    AST_JTGT_LSB: assert (func != F_JTGT || res_w[0] == 1'b0) else $error("jump target bit 0 set"); // R4
    AST_EQ_EXCL: assert (!eq_w || (!lt_w && !ltu_w)) else $error("equal and less at once"); // R6
    AST_SIGN_AGREE: assert ((opa[WIDTH-1] != opb[WIDTH-1]) || (lt_w == ltu_w)) else $error("same-sign compare mismatch"); // R7
    AST_SUB_EQ_ZERO: assert (func != F_SUB || !eq_w || res_w == '0) else $error("equal operands gave nonzero difference"); // R2
  end

  assign result   = res_w;
  assign flag_eq  = eq_w;
  assign flag_lt  = lt_w;
  assign flag_ltu = ltu_w;

endmodule

// File: tb/test_int_alu.sv
module test_int_alu;
  localparam int CLK_PERIOD = 10;
  localparam int W = 32;

  logic clk = 0;
  logic rst = 1;
  logic [W-1:0] opa, opb, result;
  logic [3:0] func;
  logic flag_eq, flag_lt, flag_ltu;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  int_alu #(.WIDTH(W)) i_int_alu (
    .opa(opa), .opb(opb), .func(func), .result(result),
    .flag_eq(flag_eq), .flag_lt(flag_lt), .flag_ltu(flag_ltu)
  );

  function automatic string tag_of(input logic [3:0] f);
    case (f)
      4'd0: return "R1";
      4'd1: return "R2";
      4'd2, 4'd3, 4'd4: return "R3";
      4'd5, 4'd6, 4'd7: return "R9";
      4'd8: return "R10";
      4'd10: return "R4";
      4'd14: return "R5";
      default: return "R11";
    endcase
  endfunction

  function automatic logic [W-1:0] model(input logic [W-1:0] a, b, input logic [3:0] f);
    logic [W-1:0] r;
    int s;
    s = int'(b[4:0]);
    case (f)
      4'd0: r = a + b;
      4'd1: r = a + (~b) + 1;
      4'd2: r = a & b;
      4'd3: r = a | b;
      4'd4: r = a ^ b;
      4'd5: r = a << s;
      4'd6: r = a >> s;
      4'd7: begin
        r = a >> s;
        if (a[W-1]) r = r | ~({W{1'b1}} >> s);
      end
      4'd8: r = b;
      4'd10: begin r = a + b; r[0] = 1'b0; end
      default: r = '0;
    endcase
    return r;
  endfunction

  task automatic chk(input string tag, input logic [W-1:0] act, exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h (func %0d opa %h opb %h)", tag, act, exp, func, opa, opb);
    end
  endtask

  task automatic apply(input logic [W-1:0] a, b, input logic [3:0] f);
    logic exp_lt;
    @(negedge clk);
    opa = a; opb = b; func = f;
    #1;
    exp_lt = ({~a[W-1], a[W-2:0]} < {~b[W-1], b[W-2:0]});
    chk(tag_of(f), result, model(a, b, f));
    chk("R6", W'(flag_eq), W'(a == b));
    chk("R7", W'(flag_lt), W'(exp_lt));
    chk("R8", W'(flag_ltu), W'(a < b));
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    finish_up();
  end

  initial begin
    void'($urandom(32'd1234));
    opa = '0; opb = '0; func = '0;
    repeat (2) @(posedge clk);
    rst = 0;
    // reset-like idle state: zero operands
    apply(32'h0, 32'h0, 4'd0);
    apply(32'hfeeeeaa3, 32'hf4650000, 4'd0);          // R1 wrap
    apply(32'h00000001, 32'hffffffff, 4'd1);          // R2
    apply(32'hffff8000, 32'h7fffffff, 4'd1);          // R2
    apply(32'h0ffaa660, 32'h00012304, 4'd2);          // R3
    apply(32'h0ffaa660, 32'h00012304, 4'd3);          // R3
    apply(32'hfff0a440, 32'h00004450, 4'd4);          // R3
    apply(32'hfff0a440, 32'h00000fff, 4'd10);         // R4
    apply(32'h00000003, 32'h00000000, 4'd10);         // R4 odd sum
    apply(32'h00132050, 32'hd6620040, 4'd14);         // R5 ltu=1
    apply(32'h80000000, 32'h00000000, 4'd14);         // R5/R7/R8 sign only
    apply(32'h00000000, 32'h80000000, 4'd0);          // R12 flags under add
    apply(32'h12345678, 32'h12345678, 4'd6);          // R6/R12
    apply(32'h80000001, 32'hffffffe4, 4'd7);          // R9 high bits of opb ignored
    apply(32'h80000001, 32'h0000001f, 4'd6);          // R9
    apply(32'h00000001, 32'h0000003f, 4'd5);          // R9
    apply(32'hdeadbeef, 32'hcafef00d, 4'd8);          // R10
    apply(32'hdeadbeef, 32'hcafef00d, 4'd9);          // R11
    apply(32'hdeadbeef, 32'hcafef00d, 4'd11);         // R11
    apply(32'hdeadbeef, 32'hcafef00d, 4'd12);         // R11
    apply(32'hdeadbeef, 32'hcafef00d, 4'd13);         // R11
    apply(32'hdeadbeef, 32'hcafef00d, 4'd15);         // R11
    for (int i = 0; i < 600; i++) begin
      logic [W-1:0] a, b;
      a = $urandom;
      b = (i % 5 == 0) ? a : $urandom;
      if (i % 7 == 0) b = a ^ 32'h80000000;
      apply(a, b, 4'($urandom % 16));
    end
    finish_up();
  end
endmodule